// File: doc/BRIEF.md
# Two-Key Register Write Guard

This block decides whether software may modify a protected control register. After reset the register is sealed. It opens only when the exact 32-bit word pair `0x45670123` then `0xCDEF89AB` arrives on the key write port, in that order. A wrong word on the key port bars the register until the next reset and raises a one-cycle bus-error pulse on the write that was wrong. A control-register write can seal the register again at any time. Writes that request an option reload always get through, even while the register is sealed.

A second, smaller sequence machine grants an option-write enable. It accepts the same two words, in the same order, on a separate option key port, but only while the main register is open. Software clears the enable with a control write. The enable also drops whenever the main register closes. Both key ports are write-only and read back as zero. A status word reports the sealed, option-enabled and barred states.

Main states: `MS_SEALED` (reset), `MS_HALF` (first key seen), `MS_OPEN` (unlocked), `MS_BARRED` (lockout).
- Transitions: SEALED to HALF on the first key.
- SEALED to BARRED, or HALF to BARRED, on any other key word.
- HALF to OPEN on the second key.
- OPEN to BARRED on any key write.
- OPEN to SEALED on a relock write.

Option states: `OS_OFF`, `OS_HALF`, `OS_ON`.
- OFF to HALF on the first key, and HALF to ON on the second key.
- A wrong option key takes OFF or HALF back to OFF with an error.
- An option key write in ON raises an error and stays in ON.
- A clear write, or the main register leaving OPEN, returns the machine to OFF.

Top module: `regkey_guard`

## Requirements
- R1: After reset the status shows sealed (`locked`=1), option write disabled (`opt_wen`=0), not barred, and `bus_err`=0.
- R2: A key-port write of 0x45670123 followed by a key-port write of 0xCDEF89AB clears `locked` in the cycle after the second write, with no bus error.
- R3: A key-port write of anything other than 0x45670123 while sealed with no key pending sets `bus_err` for exactly the cycle after that write, and bars the register.
- R4: When the first key is correct and the second key-port write is not 0xCDEF89AB, `bus_err` follows the second write, and not the first.
- R5: Once barred, the register stays sealed until reset, even after a correct key pair. Every key-port write while barred raises `bus_err`.
- R6: A control write with bit 0 set seals an open register, and the register can then be reopened with a fresh key pair. A control write with bit 0 clear leaves the lock state unchanged.
- R7: `ctl_grant` is high only during a control write while unlocked. `reload_req` is high during any control write with bit 2 set, whatever the lock state.
- R8: The option key pair (same words, same order) sets `opt_wen` only while the main register is open. While the register is sealed, option key writes change nothing and raise no error.
- R9: A wrong option key word while open raises `bus_err`, restarts the option sequence, and leaves the main register open.
- R10: While open, a control write with bit 1 clear drops `opt_wen`. Sealing the main register also drops it.
- R11: Any key-port write after a successful unlock raises `bus_err` and bars the register.
- R12: Reads of the key port (`rd_sel`=0) and the option key port (`rd_sel`=1) return zero. `rd_sel`=2 returns bit 0 = locked, bit 1 = opt_wen, bit 2 = barred, with all other bits zero. `rd_sel`=3 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_wr | input | 1 | Write strobe for the key port |
| key_wdata | input | 32 | Key-port write data |
| optkey_wr | input | 1 | Write strobe for the option key port |
| optkey_wdata | input | 32 | Option key write data |
| ctl_wr | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 32 | Control write data: bit 0 relock, bit 1 option enable keep, bit 2 reload |
| rd_sel | input | 2 | Read select: 0 key, 1 option key, 2 status, 3 none |
| rd_data | output | 32 | Read data for the selected register |
| locked | output | 1 | Control register sealed |
| opt_wen | output | 1 | Option write enable |
| bus_err | output | 1 | One-cycle pulse after a rejected key write |
| ctl_grant | output | 1 | Control write allowed through |
| reload_req | output | 1 | Option reload request, passed regardless of lock |

## Verification
The hardest situations to reach are the ones that need a long, specific history. One is a key write that arrives after a good unlock. Another is an option sequence that is cut short by a relock or by a wrong option word. Both need the whole key pair to land first, and the stimulus then has to hit exactly the next write. The bench first sweeps every ordered pair drawn from a small set of words around the two keys, starting each pair from reset. It then drives scripted chains of unlock, relock, option-key and clear writes from reset, and checks the lock, enable and error outputs after every write.

// File: rtl/regkey_pkg.sv
package regkey_pkg;

    typedef enum logic [1:0] {
        MS_SEALED = 2'd0,
        MS_HALF   = 2'd1,
        MS_OPEN   = 2'd2,
        MS_BARRED = 2'd3
    } main_st_t;

    typedef enum logic [1:0] {
        OS_OFF  = 2'd0,
        OS_HALF = 2'd1,
        OS_ON   = 2'd2
    } opt_st_t;

    localparam int CTL_RELOCK_BIT = 0;
    localparam int CTL_OPTEN_BIT  = 1;
    localparam int CTL_RELOAD_BIT = 2;

    localparam logic [1:0] RSEL_KEY    = 2'd0;
    localparam logic [1:0] RSEL_OPTKEY = 2'd1;
    localparam logic [1:0] RSEL_STATUS = 2'd2;

endpackage

// File: rtl/regkey_match.sv
module regkey_match #(
    parameter int               DATA_W = 32,
    parameter logic [DATA_W-1:0] KEY_FIRST  = 32'h4567_0123,
    parameter logic [DATA_W-1:0] KEY_SECOND = 32'hCDEF_89AB
) (
    input  logic [DATA_W-1:0] word,
    output logic              is_first,
    output logic              is_second
);
    always_comb begin
        is_first  = (word == KEY_FIRST);
        is_second = (word == KEY_SECOND);
    end
endmodule

// File: rtl/regkey_main_fsm.sv
module regkey_main_fsm
    import regkey_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic is_first,
    input  logic is_second,
    input  logic relock_req,
    output logic open_now,
    output logic open_next,
    output logic barred,
    output logic err
);
    main_st_t state_q, state_d;
    logic     err_d, err_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MS_SEALED;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            err_q   <= err_d;
        end
    end

    always_comb begin
        state_d = state_q;
        err_d   = 1'b0;
        unique case (state_q)
            MS_SEALED: begin
                if (wr) begin
                    if (is_first) begin
                        state_d = MS_HALF;
                    end else begin
                        state_d = MS_BARRED;
                        err_d   = 1'b1;
                    end
                end
            end
            MS_HALF: begin
                if (wr) begin
                    if (is_second) begin
                        state_d = MS_OPEN;
                    end else begin
                        state_d = MS_BARRED;
                        err_d   = 1'b1;
                    end
                end
            end
            MS_OPEN: begin
                if (wr) begin
                    state_d = MS_BARRED;
                    err_d   = 1'b1;
                end else if (relock_req) begin
                    state_d = MS_SEALED;
                end
            end
            MS_BARRED: begin
                if (wr) begin
                    err_d = 1'b1;
                end
            end
            default: begin
                state_d = MS_BARRED;
            end
        endcase
    end

    always_comb begin
        open_now  = (state_q == MS_OPEN);
        open_next = (state_d == MS_OPEN);
        barred    = (state_q == MS_BARRED);
        err       = err_q;
    end
endmodule

// File: rtl/regkey_opt_fsm.sv
module regkey_opt_fsm
    import regkey_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic is_first,
    input  logic is_second,
    input  logic main_open_now,
    input  logic main_open_next,
    input  logic clear_req,
    output logic enable,
    output logic err
);
    opt_st_t state_q, state_d;
    logic    err_d, err_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OS_OFF;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            err_q   <= err_d;
        end
    end

    always_comb begin
        state_d = state_q;
        err_d   = 1'b0;
        if (!main_open_now || !main_open_next) begin
            state_d = OS_OFF;
        end else if (clear_req) begin
            state_d = OS_OFF;
        end else begin
            unique case (state_q)
                OS_OFF: begin
                    if (wr) begin
                        if (is_first) begin
                            state_d = OS_HALF;
                        end else begin
                            err_d = 1'b1;
                        end
                    end
                end
                OS_HALF: begin
                    if (wr) begin
                        if (is_second) begin
                            state_d = OS_ON;
                        end else begin
                            state_d = OS_OFF;
                            err_d   = 1'b1;
                        end
                    end
                end
                OS_ON: begin
                    if (wr) begin
                        err_d = 1'b1;
                    end
                end
                default: begin
                    state_d = OS_OFF;
                end
            endcase
        end
    end

    always_comb begin
        enable = (state_q == OS_ON);
        err    = err_q;
    end
endmodule

// File: rtl/regkey_guard.sv
module regkey_guard
    import regkey_pkg::*;
#(
    parameter int                DATA_W     = 32,
    parameter logic [DATA_W-1:0] KEY_FIRST  = 32'h4567_0123,
    parameter logic [DATA_W-1:0] KEY_SECOND = 32'hCDEF_89AB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_wr,
    input  logic [DATA_W-1:0] key_wdata,
    input  logic              optkey_wr,
    input  logic [DATA_W-1:0] optkey_wdata,
    input  logic              ctl_wr,
    input  logic [DATA_W-1:0] ctl_wdata,
    input  logic [1:0]        rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic              locked,
    output logic              opt_wen,
    output logic              bus_err,
    output logic              ctl_grant,
    output logic              reload_req
);
    localparam int NPORT = 2;

    logic [DATA_W-1:0] port_word [NPORT];
    logic [NPORT-1:0]  hit_first;
    logic [NPORT-1:0]  hit_second;

    assign port_word[0] = key_wdata;
    assign port_word[1] = optkey_wdata;

    for (genvar p = 0; p < NPORT; p++) begin : g_match
        regkey_match #(
            .DATA_W    (DATA_W),
            .KEY_FIRST (KEY_FIRST),
            .KEY_SECOND(KEY_SECOND)
        ) u_match (
            .word     (port_word[p]),
            .is_first (hit_first[p]),
            .is_second(hit_second[p])
        );
    end

    logic open_now, open_next, lockout, main_err, opt_err, opt_en;
    logic relock_req, clear_req;

    always_comb begin
        relock_req = ctl_wr && ctl_wdata[CTL_RELOCK_BIT];
        clear_req  = ctl_wr && open_now && !ctl_wdata[CTL_OPTEN_BIT];
    end

    regkey_main_fsm u_main (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (key_wr),
        .is_first  (hit_first[0]),
        .is_second (hit_second[0]),
        .relock_req(relock_req),
        .open_now  (open_now),
        .open_next (open_next),
        .barred    (lockout),
        .err       (main_err)
    );

    regkey_opt_fsm u_opt (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr            (optkey_wr),
        .is_first      (hit_first[1]),
        .is_second     (hit_second[1]),
        .main_open_now (open_now),
        .main_open_next(open_next),
        .clear_req     (clear_req),
        .enable        (opt_en),
        .err           (opt_err)
    );

    always_comb begin
        locked     = !open_now;
        opt_wen    = opt_en;
        bus_err    = main_err || opt_err;
        ctl_grant  = ctl_wr && open_now;
        reload_req = ctl_wr && ctl_wdata[CTL_RELOAD_BIT];
        rd_data    = '0;
        if (rd_sel == RSEL_STATUS) begin
            rd_data[0] = !open_now;
            rd_data[1] = opt_en;
            rd_data[2] = lockout;
        end
    end
endmodule

// File: rtl/regkey_guard_chk.sv
module regkey_guard_chk #(
    parameter int                DATA_W     = 32,
    parameter logic [DATA_W-1:0] KEY_FIRST  = 32'h4567_0123,
    parameter logic [DATA_W-1:0] KEY_SECOND = 32'hCDEF_89AB
) (
    input logic              clk,
    input logic              rst_n,
    input logic              key_wr,
    input logic [DATA_W-1:0] key_wdata,
    input logic              optkey_wr,
    input logic [DATA_W-1:0] optkey_wdata,
    input logic              ctl_wr,
    input logic [DATA_W-1:0] ctl_wdata,
    input logic              locked,
    input logic              opt_wen,
    input logic              bus_err,
    input logic              lockout
);
    AST_UNLOCK_NEEDS_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> $past(key_wr && key_wdata == KEY_SECOND)); // R2

    AST_ERR_FROM_KEY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(key_wr || optkey_wr)); // R3

    AST_LOCKOUT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        lockout |=> (lockout && locked)); // R5

    AST_RESEAL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(key_wr || (ctl_wr && ctl_wdata[0]))); // R6

    AST_OPT_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        opt_wen |-> !locked); // R8

    AST_OPT_RISE_ON_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(opt_wen) |-> $past(optkey_wr && optkey_wdata == KEY_SECOND)); // R8

    AST_KEY_AFTER_OPEN_BARS: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && key_wr) |=> (lockout && bus_err)); // R11
endmodule

bind regkey_guard regkey_guard_chk #(
    .DATA_W    (DATA_W),
    .KEY_FIRST (KEY_FIRST),
    .KEY_SECOND(KEY_SECOND)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .key_wr      (key_wr),
    .key_wdata   (key_wdata),
    .optkey_wr   (optkey_wr),
    .optkey_wdata(optkey_wdata),
    .ctl_wr      (ctl_wr),
    .ctl_wdata   (ctl_wdata),
    .locked      (locked),
    .opt_wen     (opt_wen),
    .bus_err     (bus_err),
    .lockout     (lockout)
);

// File: tb/regkey_guard_test.sv
`timescale 1ns/1ps
module regkey_guard_test;
    localparam logic [31:0] K1 = 32'h4567_0123;
    localparam logic [31:0] K2 = 32'hCDEF_89AB;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        key_wr = 1'b0, optkey_wr = 1'b0, ctl_wr = 1'b0;
    logic [31:0] key_wdata = '0, optkey_wdata = '0, ctl_wdata = '0;
    logic [1:0]  rd_sel = 2'd2;
    logic [31:0] rd_data;
    logic        locked, opt_wen, bus_err, ctl_grant, reload_req;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    regkey_guard uut (
        .clk(clk), .rst_n(rst_n),
        .key_wr(key_wr), .key_wdata(key_wdata),
        .optkey_wr(optkey_wr), .optkey_wdata(optkey_wdata),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .rd_sel(rd_sel), .rd_data(rd_data),
        .locked(locked), .opt_wen(opt_wen), .bus_err(bus_err),
        .ctl_grant(ctl_grant), .reload_req(reload_req)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] cand(input int i);
        case (i)
            0: cand = K1;
            1: cand = K2;
            2: cand = 32'h0;
            3: cand = 32'hFFFF_FFFF;
            4: cand = K1 ^ 32'h1;
            default: cand = K2 ^ 32'h8000_0000;
        endcase
    endfunction

    function automatic logic [31:0] status(input logic lk, input logic oe, input logic bar);
        status = {29'b0, bar, oe, lk};
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr_key(input logic [31:0] d);
        key_wr = 1'b1; key_wdata = d;
        @(negedge clk);
        key_wr = 1'b0;
    endtask

    task automatic wr_opt(input logic [31:0] d);
        optkey_wr = 1'b1; optkey_wdata = d;
        @(negedge clk);
        optkey_wr = 1'b0;
    endtask

    task automatic wr_ctl(input logic [31:0] d);
        ctl_wr = 1'b1; ctl_wdata = d;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got hang expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1", rd_data, status(1'b1, 1'b0, 1'b0));
        chk("R1", {31'b0, bus_err}, 32'd0);

        // R2 R3 R4 sweep over ordered pairs
        for (int i = 0; i < 6; i++) begin
            for (int j = 0; j < 6; j++) begin
                logic e1, e2, lk;
                do_reset();
                e1 = (cand(i) != K1);
                wr_key(cand(i));
                chk(e1 ? "R3" : "R4", {31'b0, bus_err}, {31'b0, e1});
                chk("R3", rd_data, status(1'b1, 1'b0, e1));
                e2 = e1 || (cand(j) != K2);
                lk = e2;
                wr_key(cand(j));
                chk(e1 ? "R5" : "R4", {31'b0, bus_err}, {31'b0, e2});
                chk("R2", {31'b0, locked}, {31'b0, lk});
                @(negedge clk);
                chk("R3", {31'b0, bus_err}, 32'd0);
            end
        end

        // R5 barred stays sealed even after a correct pair
        do_reset();
        wr_key(32'h1234_5678);
        wr_key(K1);
        chk("R5", {31'b0, bus_err}, 32'd1);
        wr_key(K2);
        chk("R5", rd_data, status(1'b1, 1'b0, 1'b1));
        wr_ctl(32'h0);
        chk("R5", {31'b0, locked}, 32'd1);

        // R6 relock and reopen
        do_reset();
        wr_key(K1); wr_key(K2);
        wr_ctl(32'h0);
        chk("R6", {31'b0, locked}, 32'd0);
        wr_ctl(32'h1);
        chk("R6", {31'b0, locked}, 32'd1);
        chk("R6", {31'b0, bus_err}, 32'd0);
        wr_key(K1); wr_key(K2);
        chk("R6", rd_data, status(1'b0, 1'b0, 1'b0));

        // R7 grant and reload paths
        ctl_wr = 1'b1; ctl_wdata = 32'h4;
        #1;
        chk("R7", {30'b0, ctl_grant, reload_req}, 32'd3);
        @(negedge clk); ctl_wr = 1'b0;
        do_reset();
        ctl_wr = 1'b1; ctl_wdata = 32'h4;
        #1;
        chk("R7", {30'b0, ctl_grant, reload_req}, 32'd1);
        ctl_wdata = 32'h2;
        #1;
        chk("R7", {30'b0, ctl_grant, reload_req}, 32'd0);
        @(negedge clk); ctl_wr = 1'b0;

        // R8 option keys ignored while sealed
        wr_opt(K1);
        chk("R8", {31'b0, bus_err}, 32'd0);
        wr_opt(K2);
        chk("R8", rd_data, status(1'b1, 1'b0, 1'b0));
        wr_key(K1); wr_key(K2);
        wr_opt(K2);
        chk("R8", {31'b0, opt_wen}, 32'd0);
        wr_opt(K1); wr_opt(K2);
        chk("R8", rd_data, status(1'b0, 1'b1, 1'b0));

        // R10 clear with bit 1 low; keep with bit 1 high
        wr_ctl(32'h2);
        chk("R10", {31'b0, opt_wen}, 32'd1);
        wr_ctl(32'h0);
        chk("R10", {31'b0, opt_wen}, 32'd0);
        wr_opt(K1); wr_opt(K2);
        wr_ctl(32'h3);
        chk("R10", rd_data, status(1'b1, 1'b0, 1'b0));

        // R9 wrong option word restarts and keeps main open
        wr_key(K1); wr_key(K2);
        wr_opt(K1);
        wr_opt(32'h0);
        chk("R9", {31'b0, bus_err}, 32'd1);
        chk("R9", rd_data, status(1'b0, 1'b0, 1'b0));
        wr_opt(K2);
        chk("R9", {31'b0, opt_wen}, 32'd0);
        wr_opt(K1); wr_opt(K2);
        chk("R9", {31'b0, opt_wen}, 32'd1);

        // R11 key write after unlock bars and drops option
        wr_key(K1);
        chk("R11", {31'b0, bus_err}, 32'd1);
        chk("R11", rd_data, status(1'b1, 1'b0, 1'b1));

        // R12 read-back of key ports
        for (int s = 0; s < 4; s++) begin
            rd_sel = s[1:0];
            #1;
            chk("R12", rd_data, (s == 2) ? status(1'b1, 1'b0, 1'b1) : 32'd0);
        end
        rd_sel = 2'd2;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule